// File: doc/BRIEF.md
# Single-Cycle 16-Bit Load/Store Core

This block is a compact processor core that completes one 16-bit instruction per clock. It fetches from an instruction memory and reads or writes a separate data memory. Both memories are word addressed: every 16-bit address holds one 16-bit word, so sequential execution steps the program counter by one. The core holds eight 16-bit general registers, named r1 to r8 and encoded as indices 0 to 7. It also holds a link register that sits outside that file and serves calls and returns.

The instruction set has three groups:
- Register and small-immediate arithmetic and logic, plus register copy and load-immediate.
- Word loads and stores addressed by a register.
- Two conditional branches, an unconditional jump, a call that saves its return address, a return, and a halt.

The halt freezes the whole core until reset. The three 3-bit register fields lie in a 9-bit window whose lowest bit is set by the parameter `FIELD_LSB`, from 0 to 6. The other seven bits form the opcode, and the opcode alone selects the operation.

Memory reads are combinational, so the memories sit outside the block. All state changes on the rising clock edge.

Top module: `sc16_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all eight registers, the link register and the halted flag clear to zero. After reset, fetch starts at address 0 with `halted` low.
- R2: Fields are located from `FIELD_LSB` = Y:
  - A = bits Y..Y+2, B = bits Y+3..Y+5, C = bits Y+6..Y+8.
  - The opcode is the other seven bits, gathered from bit 0 upward.
  - Opcode values: 1 li, 2 add, 3 and, 4 or, 5 ld, 6 st, 7 move, 8 addi, 9 andi, 10 ori, 11 ble, 12 bne, 13 jump, 14 call, 15 rtn, 16 halt.
- R3: add, and and or write A with B op C. The addition wraps modulo 2^16.
- R4: addi, andi and ori write A with B op imm. imm is field C sign-extended from 3 bits.
- R5: li writes A with the 6-bit value {C,B} sign-extended. move writes A with the value of B.
- R6: ld writes A with the data word at the address held in B. st writes the value of A to the data word at the address held in B, and only st raises `dmem_we`.
- R7: ble compares A and B as signed two's-complement values. When A <= B it goes to PC + off, otherwise to PC + 1. off is field C sign-extended from 3 bits, and PC is the address of the ble itself.
- R8: bne goes to PC + off (off as in R7) when A differs from B, otherwise to PC + 1.
- R9: jump goes to PC + off, where off is the 9-bit value {C,B,A} sign-extended.
- R10: call goes to PC + off (offset as in R9) and in the same edge loads the link register with PC + 1. rtn loads the PC from the link register.
- R11: After a halt executes, `halted` is high and the PC stays on the halt's address. No register, link or memory write happens until reset.
- R12: An opcode not listed in R2 changes no register and no memory, and the PC advances by one.
- R13: Every instruction other than a taken control transfer or a halt advances the PC by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Data memory address for loads and stores |
| dmem_rdata | input | 16 | Data word at `dmem_addr` |
| dmem_wdata | output | 16 | Data to store |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| halted | output | 1 | High once a halt has executed |

## Verification
A table of ALU cases runs through short programs that load operands from data memory, operate, and store the result. The cases separate wrap-around addition, the AND and OR masks, negative versus positive 3-bit immediates, and sign extension of the 6-bit load-immediate.

Branch programs use the pair (-1, 1) to tell a signed ble from an unsigned one. They also cover equal operands, which must take ble and must not take bne, and a backward offset of -1 that forms a counting loop. A call, return and forward-jump program checks the saved link value and the return path.

Further programs check a halt followed by instructions that must not run, and an undefined opcode that must act as a no-op. The bench runs at `FIELD_LSB` = 3, so the opcode bits are split on both sides of the field window.

// File: rtl/sc16_pkg.sv
package sc16_pkg;
    localparam int WORD_W     = 16;
    localparam int REG_CNT    = 8;
    localparam int RIDX_W     = $clog2(REG_CNT);
    localparam int FIELD_SPAN = 3 * RIDX_W;
    localparam int OPC_W      = WORD_W - FIELD_SPAN;
    localparam int OPC_IDX_W  = $clog2(OPC_W);
    localparam int WORD_IDX_W = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_LI   = opc_t'(1);
    localparam opc_t OPC_ADD  = opc_t'(2);
    localparam opc_t OPC_AND  = opc_t'(3);
    localparam opc_t OPC_OR   = opc_t'(4);
    localparam opc_t OPC_LD   = opc_t'(5);
    localparam opc_t OPC_ST   = opc_t'(6);
    localparam opc_t OPC_MOVE = opc_t'(7);
    localparam opc_t OPC_ADDI = opc_t'(8);
    localparam opc_t OPC_ANDI = opc_t'(9);
    localparam opc_t OPC_ORI  = opc_t'(10);
    localparam opc_t OPC_BLE  = opc_t'(11);
    localparam opc_t OPC_BNE  = opc_t'(12);
    localparam opc_t OPC_JUMP = opc_t'(13);
    localparam opc_t OPC_CALL = opc_t'(14);
    localparam opc_t OPC_RTN  = opc_t'(15);
    localparam opc_t OPC_HALT = opc_t'(16);

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_AND,
        ALU_OR,
        ALU_PASS_A,
        ALU_PASS_B
    } alu_op_e;

    typedef enum logic [2:0] {
        NPC_SEQ,
        NPC_REL,
        NPC_LE,
        NPC_NE,
        NPC_RET,
        NPC_HOLD
    } npc_sel_e;

    typedef struct packed {
        ridx_t    rd;
        ridx_t    rs1;
        ridx_t    rs2;
        alu_op_e  alu_op;
        logic     use_imm;
        word_t    imm;
        logic     reg_we;
        logic     from_mem;
        logic     mem_we;
        logic     link_we;
        npc_sel_e npc_sel;
        logic     halt;
    } ctrl_t;

    // Gather the bits outside the register-field window, lowest first.
    function automatic opc_t opc_of(word_t w, int lsb);
        opc_t o;
        int   k;
        o = '0;
        k = 0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < lsb || i >= lsb + FIELD_SPAN) begin
                if (k < OPC_W) o[k[OPC_IDX_W-1:0]] = w[i[WORD_IDX_W-1:0]];
                k++;
            end
        end
        return o;
    endfunction

    // Sign-extend the low 'bits' bits of raw to a full word.
    function automatic word_t sext(word_t raw, int bits);
        word_t sh;
        sh = raw << (WORD_W - bits);
        return word_t'($signed(sh) >>> (WORD_W - bits));
    endfunction
endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
    import sc16_pkg::*;
#(
    parameter int FIELD_LSB = 0
) (
    input  word_t instr,
    output ctrl_t ctrl
);
    localparam int F_A = FIELD_LSB;
    localparam int F_B = FIELD_LSB + RIDX_W;
    localparam int F_C = FIELD_LSB + 2 * RIDX_W;

    ridx_t fa, fb, fc;
    opc_t  opc;

    assign fa  = instr[F_A +: RIDX_W];
    assign fb  = instr[F_B +: RIDX_W];
    assign fc  = instr[F_C +: RIDX_W];
    assign opc = opc_of(instr, FIELD_LSB);

    always_comb begin
        ctrl         = '0;
        ctrl.rd      = fa;
        ctrl.rs1     = fb;
        ctrl.rs2     = fc;
        ctrl.alu_op  = ALU_ADD;
        ctrl.npc_sel = NPC_SEQ;
        case (opc)
            OPC_LI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_PASS_B;
                ctrl.imm     = sext(word_t'({fc, fb}), 2 * RIDX_W);
            end
            OPC_ADD: begin
                ctrl.reg_we = 1'b1;
            end
            OPC_AND: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_AND;
            end
            OPC_OR: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_OR;
            end
            OPC_LD: begin
                ctrl.reg_we   = 1'b1;
                ctrl.from_mem = 1'b1;
                ctrl.rs2      = fb;
            end
            OPC_ST: begin
                ctrl.mem_we = 1'b1;
                ctrl.rs1    = fa;
                ctrl.rs2    = fb;
            end
            OPC_MOVE: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = ALU_PASS_A;
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.imm     = sext(word_t'(fc), RIDX_W);
                ctrl.alu_op  = (opc == OPC_ADDI) ? ALU_ADD :
                               (opc == OPC_ANDI) ? ALU_AND : ALU_OR;
            end
            OPC_BLE, OPC_BNE: begin
                ctrl.rs1     = fa;
                ctrl.rs2     = fb;
                ctrl.imm     = sext(word_t'(fc), RIDX_W);
                ctrl.npc_sel = (opc == OPC_BLE) ? NPC_LE : NPC_NE;
            end
            OPC_JUMP, OPC_CALL: begin
                ctrl.imm     = sext(word_t'({fc, fb, fa}), FIELD_SPAN);
                ctrl.npc_sel = NPC_REL;
                ctrl.link_we = (opc == OPC_CALL);
            end
            OPC_RTN: begin
                ctrl.npc_sel = NPC_RET;
            end
            OPC_HALT: begin
                ctrl.halt    = 1'b1;
                ctrl.npc_sel = NPC_HOLD;
            end
            default: begin
                // Undefined opcode: behaves as a no-op.
            end
        endcase
    end
endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
    import sc16_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        case (op)
            ALU_ADD:    y = a + b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end
endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile
    import sc16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t raddr1,
    input  ridx_t raddr2,
    output word_t rdata1,
    output word_t rdata2
);
    word_t regs [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata1 = regs[raddr1];
    assign rdata2 = regs[raddr2];

    // R3: an enabled write is visible in the addressed register one edge later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));

    // R1: reset leaves every register reading zero
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (regs[raddr1] == '0));
endmodule

// File: rtl/sc16_nextpc.sv
module sc16_nextpc
    import sc16_pkg::*;
(
    input  npc_sel_e sel,
    input  word_t    pc,
    input  word_t    offset,
    input  word_t    opa,
    input  word_t    opb,
    input  word_t    link,
    output word_t    npc,
    output word_t    pc_inc
);
    word_t target;
    logic  le_hit;
    logic  ne_hit;

    assign pc_inc = pc + word_t'(1);
    assign target = pc + offset;
    assign le_hit = $signed(opa) <= $signed(opb);
    assign ne_hit = opa != opb;

    always_comb begin
        case (sel)
            NPC_SEQ:  npc = pc_inc;
            NPC_REL:  npc = target;
            NPC_LE:   npc = le_hit ? target : pc_inc;
            NPC_NE:   npc = ne_hit ? target : pc_inc;
            NPC_RET:  npc = link;
            NPC_HOLD: npc = pc;
            default:  npc = pc_inc;
        endcase
    end
endmodule

// File: rtl/sc16_core.sv
module sc16_core
    import sc16_pkg::*;
#(
    parameter int FIELD_LSB = 0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    output logic [WORD_W-1:0] dmem_addr,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    output logic              halted
);
    word_t pc_q;
    word_t link_q;
    logic  halted_q;
    ctrl_t ctrl;
    word_t rdata1, rdata2;
    word_t alu_b, alu_y, wb_data;
    word_t npc, pc_inc;
    logic  rf_we;

    sc16_decode #(.FIELD_LSB(FIELD_LSB)) u_decode (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    assign rf_we   = ctrl.reg_we & ~halted_q;
    assign wb_data = ctrl.from_mem ? dmem_rdata : alu_y;

    sc16_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (ctrl.rd),
        .wdata  (wb_data),
        .raddr1 (ctrl.rs1),
        .raddr2 (ctrl.rs2),
        .rdata1 (rdata1),
        .rdata2 (rdata2)
    );

    assign alu_b = ctrl.use_imm ? ctrl.imm : rdata2;

    sc16_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rdata1),
        .b  (alu_b),
        .y  (alu_y)
    );

    sc16_nextpc u_npc (
        .sel    (ctrl.npc_sel),
        .pc     (pc_q),
        .offset (ctrl.imm),
        .opa    (rdata1),
        .opb    (rdata2),
        .link   (link_q),
        .npc    (npc),
        .pc_inc (pc_inc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            link_q   <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            pc_q <= npc;
            if (ctrl.link_we) link_q <= pc_inc;
            if (ctrl.halt) halted_q <= 1'b1;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = rdata2;
    assign dmem_wdata = rdata1;
    assign dmem_we    = ctrl.mem_we & ~halted_q;
    assign halted     = halted_q;

    // R11: once halted, PC, link and flag hold still
    p_halt_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q && $stable(pc_q) && $stable(link_q));

    // R11: no store leaves a halted core
    p_halt_no_store_r11: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> !dmem_we);

    // R10: a call saves the address after itself
    p_call_link_r10: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && ctrl.link_we) |=> link_q == $past(pc_q) + 16'd1);

    // R10: a return resumes at the saved address
    p_return_r10: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && ctrl.npc_sel == NPC_RET) |=> pc_q == $past(link_q));

    // R13: a non-transfer instruction steps the PC by one
    p_seq_step_r13: assert property (@(posedge clk) disable iff (rst)
        (!halted_q && ctrl.npc_sel == NPC_SEQ) |=> pc_q == $past(pc_q) + 16'd1);

    // R6: a register write and a store never coincide
    p_one_sink_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, dmem_we}));
endmodule

// File: tb/sc16_core_tb.sv
module sc16_core_tb;
    localparam int Y = 3;
    localparam int MW = 64;
    localparam int G1 = 0, G2 = 1, G3 = 2, G4 = 3, G5 = 4, G6 = 5, G7 = 6, G8 = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
    logic        dmem_we, halted;

    logic [15:0] imem [MW];
    logic [15:0] dmem [MW];
    logic        clr = 1'b1;
    logic [15:0] pre0 = '0, pre1 = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sc16_core #(.FIELD_LSB(Y)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .halted     (halted)
    );

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < MW; i++) dmem[i] <= 16'hDEAD;
            dmem[0] <= pre0;
            dmem[1] <= pre1;
        end else if (dmem_we) begin
            dmem[dmem_addr[5:0]] <= dmem_wdata;
        end
    end

    // Encoder built from R2: fields at Y, opcode bits around them from bit 0 up.
    function automatic logic [15:0] enc(int op, int fa, int fb, int fc);
        logic [15:0] w;
        int k;
        w = '0;
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < Y || i >= Y + 9) begin
                w[i] = op[k];
                k++;
            end
        end
        w[Y +: 3]     = fa[2:0];
        w[Y + 3 +: 3] = fb[2:0];
        w[Y + 6 +: 3] = fc[2:0];
        return w;
    endfunction

    function automatic logic [15:0] i_li(int rd, int v);
        return enc(1, rd, v & 7, (v >> 3) & 7);
    endfunction
    function automatic logic [15:0] i_jmp(int op, int off);
        return enc(op, off & 7, (off >> 3) & 7, (off >> 6) & 7);
    endfunction
    function automatic logic [15:0] i_halt();
        return enc(16, 0, 0, 0);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < MW; i++) imem[i] = i_halt();
    endtask

    task automatic run_prog(int limit);
        @(negedge clk);
        rst = 1'b1;
        clr = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clr = 1'b0;
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 actual=no-halt expected=halt");
        end
    endtask

    typedef struct packed {
        logic [4:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [5:0]  imm;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd2,  16'h0005, 16'h0003, 6'h00, 16'h0008},
        '{5'd2,  16'hFFFF, 16'h0001, 6'h00, 16'h0000},
        '{5'd3,  16'hF0F0, 16'h3C3C, 6'h00, 16'h3030},
        '{5'd4,  16'hF0F0, 16'h0F01, 6'h00, 16'hFFF1},
        '{5'd7,  16'h1234, 16'h5555, 6'h00, 16'h1234},
        '{5'd8,  16'h0010, 16'h0000, 6'h3F, 16'h000F},
        '{5'd8,  16'h7FFF, 16'h0000, 6'h01, 16'h8000},
        '{5'd9,  16'h00FF, 16'h0000, 6'h03, 16'h0003},
        '{5'd9,  16'h1234, 16'h0000, 6'h3E, 16'h1234},
        '{5'd10, 16'h0100, 16'h0000, 6'h02, 16'h0102},
        '{5'd10, 16'h0000, 16'h0000, 6'h3C, 16'hFFFC},
        '{5'd1,  16'h0000, 16'h0000, 6'h2C, 16'hFFEC},
        '{5'd1,  16'h0000, 16'h0000, 6'h1F, 16'h001F}
    };

    function automatic string tag_of(int op);
        if (op == 1 || op == 7) return "R5";
        if (op >= 8) return "R4";
        return "R3";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state at the first sample after reset release
        clear_prog();
        imem[0] = i_li(G1, 1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 pc", imem_addr, 16'h0000);
        check("R1 halted", {15'd0, halted}, 16'h0000);
        rst = 1'b0;
        clr = 1'b0;

        // Vector table: ld operands (R6), operate, store result
        for (int v = 0; v < NV; v++) begin
            clear_prog();
            pre0 = VECS[v].a;
            pre1 = VECS[v].b;
            imem[0] = i_li(G8, 0);
            imem[1] = enc(5, G1, G8, 0);
            imem[2] = i_li(G8, 1);
            imem[3] = enc(5, G2, G8, 0);
            if (VECS[v].op == 1)
                imem[4] = i_li(G3, int'($signed(VECS[v].imm)));
            else if (VECS[v].op >= 8)
                imem[4] = enc(int'(VECS[v].op), G3, G1, int'(VECS[v].imm[2:0]));
            else
                imem[4] = enc(int'(VECS[v].op), G3, G1, G2);
            imem[5] = i_li(G8, 2);
            imem[6] = enc(6, G3, G8, 0);
            run_prog(50);
            check(tag_of(int'(VECS[v].op)), dmem[2], VECS[v].exp);
            if (v == 0) check("R13 halt pc", imem_addr, 16'd7);
        end

        // R7: backward offset -1 loop, counts 3,6,9,12
        clear_prog();
        imem[0] = i_li(G3, 10);
        imem[1] = i_li(G1, 3);
        imem[2] = enc(2, G2, G1, G2);
        imem[3] = enc(11, G2, G3, -1);
        imem[4] = i_li(G8, 5);
        imem[5] = enc(6, G2, G8, 0);
        run_prog(100);
        check("R7 loop", dmem[5], 16'h000C);
        check("R7 pc", imem_addr, 16'd6);

        // R7/R8: signed compare, equal operands
        clear_prog();
        imem[0]  = i_li(G1, -1);
        imem[1]  = i_li(G2, 1);
        imem[2]  = i_li(G4, 5);
        imem[3]  = enc(11, G1, G2, 2);
        imem[4]  = i_li(G4, 9);
        imem[5]  = i_li(G8, 6);
        imem[6]  = enc(6, G4, G8, 0);
        imem[7]  = enc(12, G1, G1, 2);
        imem[8]  = i_li(G5, 1);
        imem[9]  = i_li(G8, 7);
        imem[10] = enc(6, G5, G8, 0);
        imem[11] = enc(12, G1, G2, 2);
        imem[12] = i_li(G5, 3);
        imem[13] = enc(11, G2, G1, 2);
        imem[14] = enc(8, G5, G5, 2);
        imem[15] = i_li(G8, 8);
        imem[16] = enc(6, G5, G8, 0);
        imem[17] = enc(11, G2, G2, 2);
        imem[18] = i_halt();
        imem[19] = i_halt();
        run_prog(100);
        check("R7 signed taken", dmem[6], 16'h0005);
        check("R8 equal not taken", dmem[7], 16'h0001);
        check("R8 taken / R7 not taken", dmem[8], 16'h0003);
        check("R7 equal taken", imem_addr, 16'd19);

        // R9/R10: call, return, forward jump
        clear_prog();
        imem[0]  = i_li(G3, 4);
        imem[1]  = i_jmp(14, 4);
        imem[2]  = i_li(G8, 9);
        imem[3]  = enc(6, G4, G8, 0);
        imem[4]  = i_jmp(13, 4);
        imem[5]  = enc(2, G4, G3, G3);
        imem[6]  = enc(15, 0, 0, 0);
        imem[7]  = i_halt();
        imem[8]  = i_li(G8, 10);
        imem[9]  = enc(6, G3, G8, 0);
        imem[10] = i_halt();
        run_prog(100);
        check("R10 call/return", dmem[9], 16'h0008);
        check("R9 jump", dmem[10], 16'h0004);
        check("R9 pc", imem_addr, 16'd10);

        // R11: halt freezes, nothing after it runs
        clear_prog();
        imem[0] = i_li(G8, 11);
        imem[1] = enc(6, G8, G8, 0);
        imem[2] = i_halt();
        imem[3] = i_li(G8, 12);
        imem[4] = enc(6, G8, G8, 0);
        run_prog(50);
        repeat (8) @(negedge clk);
        check("R11 pc held", imem_addr, 16'd2);
        check("R11 halted", {15'd0, halted}, 16'h0001);
        check("R11 no store", {15'd0, dmem_we}, 16'h0000);
        check("R11 store before halt", dmem[11], 16'd11);
        check("R11 no later store", dmem[12], 16'hDEAD);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset clears halt", {15'd0, halted}, 16'h0000);
        check("R1 reset pc", imem_addr, 16'h0000);
        rst = 1'b0;

        // R12: undefined opcode is a no-op
        clear_prog();
        imem[0] = i_li(G1, 5);
        imem[1] = enc(85, G1, G1, G1);
        imem[2] = i_li(G8, 13);
        imem[3] = enc(6, G1, G8, 0);
        run_prog(50);
        check("R12 reg intact", dmem[13], 16'h0005);
        check("R12 pc step", imem_addr, 16'd4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule